// File: doc/BRIEF.md
# Serial Bus Master Host Register Front End

This block sits between a byte-wide host bus and the engine of a serial bus master. The host selects one of five registers with a 3-bit select and moves bytes over an 8-bit data bus using active-low chip enable, read and write strobes. The block holds the command, interrupt-enable and clock-divisor registers. It forwards transmit bytes to the byte engine as a one-cycle load pulse. It returns receive data and the engine's status flags, and drives an active-low interrupt line.

The strobes are asynchronous to the system clock. They are synchronised, and each register update or read side effect happens once per detected falling edge of a strobe. An address strobe captures the select on its rising edge. While the address strobe is held low, the select passes straight through. The transmit shifter, serial line timing and clock divider live elsewhere and only connect to this block's outputs and flag inputs.

Top module: `sbm_host_regs`

## Requirements
- R1: Select 0 is the command register, select 3 is interrupt enable and select 4 is clock divisor. A write stores the data and a read at the same select returns it. No other event alters these registers.
- R2: While `addrStrobeN` is low the select follows `selIn`. On its rising edge the select is captured, and changes on `selIn` are ignored while it stays high.
- R3: When `chipEnN` is high, strobes cause no register change and no pulse, and `dataOe` stays low. `dataOe` is high exactly when `chipEnN` and `rdN` are low and `wrN` is high. `dataOut` is 0 whenever `dataOe` is low.
- R4: When `rdN` and `wrN` are low together, the write is performed and the read side effects (receive clear, interrupt clear) do not happen.
- R5: `irqN` goes low one clock after an interrupt source becomes both flagged and enabled. This includes enabling a source that is already flagged.
- R6: A read at select 2 returns `irqN` high, unless a new enabled source appears in the same cycle.
- R7: Master reset `rst` (active high) clears every register and pulse and drives `irqN` high.
- R8: A write at select 1 raises `txLoad` for exactly one clock, with the byte on `txData`. `txData` holds that byte until the next such write.
- R9: A read at select 1 returns `rxData` and raises `rxClear` for exactly one clock.
- R10: Selects 5, 6 and 7 read as zero, and writes to them change nothing.
- R11: The status register at select 2 reads presence at bit 0, transmit-buffer-empty at bit 2, shifter-empty at bit 3 and receive-full at bit 4, with all other bits 0. Interrupt enable keeps only those four bits. The divisor keeps only bits 4:0.
- R12: A strobe low level is first sampled at some clock edge. Its register update or pulse takes effect at the second edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| selIn | input | 3 | Register select |
| addrStrobeN | input | 1 | Address strobe, active low, captures select on rising edge |
| chipEnN | input | 1 | Chip enable, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data |
| dataOe | output | 1 | High while the block drives the read bus |
| irqN | output | 1 | Interrupt, active low |
| cmdReg | output | 8 | Command register contents |
| divReg | output | 8 | Clock divisor register contents |
| txLoad | output | 1 | One-cycle transmit load pulse |
| txData | output | 8 | Byte for the transmit path |
| rxClear | output | 1 | One-cycle pulse clearing receive-full |
| rxData | input | 8 | Received byte from the engine |
| flagPresence | input | 1 | Presence / reset-done status |
| flagTbe | input | 1 | Transmit buffer empty status |
| flagTemt | input | 1 | Transmit shifter empty status |
| flagRbf | input | 1 | Receive buffer full status |

## Verification
Assertions check four things on every cycle. Load and clear pulses never last two cycles. Disabled chip enable and unused selects produce no strobe. The divisor changes only on its own write. An interrupt-register read with no new source leaves `irqN` high. Other behaviour needs the bench's scenarios, driven against a cycle-accurate reference model. These cover address latch capture when the select changes behind a raised strobe, write precedence over a simultaneous read, and re-arming of the interrupt when a source is enabled after it was already flagged. They also cover the two-edge update latency and the masking of unimplemented bits.

// File: rtl/sbm_host_pkg.sv
package sbm_host_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_XFER = 3'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_IEN  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DIV  = 3'd4;

  localparam int BIT_PRES = 0;
  localparam int BIT_TBE  = 2;
  localparam int BIT_TEMT = 3;
  localparam int BIT_RBF  = 4;

  localparam logic [DATA_W-1:0] IEN_MASK = DATA_W'((1 << BIT_PRES) | (1 << BIT_TBE) |
                                                   (1 << BIT_TEMT) | (1 << BIT_RBF));
  localparam int DIV_BITS = 5;
  localparam logic [DATA_W-1:0] DIV_MASK = DATA_W'((1 << DIV_BITS) - 1);

  typedef struct packed {
    logic wrCmd;
    logic wrTx;
    logic wrIen;
    logic wrDiv;
    logic rdRx;
    logic rdIrq;
  } hostStrobeT;
endpackage

// File: rtl/sbm_host_ctrl.sv
module sbm_host_ctrl
  import sbm_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] selIn,
  input  logic             addrStrobeN,
  input  logic             chipEnN,
  input  logic             rdN,
  input  logic             wrN,
  output logic [SEL_W-1:0] effSel,
  output hostStrobeT       strobes
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] wrPipe, rdPipe;
  logic [SEL_W-1:0]  selHeld;
  logic              wrFall, rdFall;

  // synchronise both strobes; the extra stage serves edge detection
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wrPipe <= '1;
      rdPipe <= '1;
    end else begin
      wrPipe <= {wrPipe[PIPE_W-2:0], wrN};
      rdPipe <= {rdPipe[PIPE_W-2:0], rdN};
    end
  end

  // select latch: transparent while the address strobe is low
  always_ff @(posedge clk or posedge rst) begin
    if (rst) selHeld <= '0;
    else if (!addrStrobeN) selHeld <= selIn;
  end

  assign effSel = addrStrobeN ? selHeld : selIn;

  assign wrFall = wrPipe[PIPE_W-1] & ~wrPipe[PIPE_W-2];
  // a read edge counts only while the synchronised write is idle
  assign rdFall = rdPipe[PIPE_W-1] & ~rdPipe[PIPE_W-2] & wrPipe[PIPE_W-2];

  always_comb begin
    strobes = '0;
    if (!chipEnN) begin
      strobes.wrCmd = wrFall && (effSel == SEL_CMD);
      strobes.wrTx  = wrFall && (effSel == SEL_XFER);
      strobes.wrIen = wrFall && (effSel == SEL_IEN);
      strobes.wrDiv = wrFall && (effSel == SEL_DIV);
      strobes.rdRx  = rdFall && (effSel == SEL_XFER);
      strobes.rdIrq = rdFall && (effSel == SEL_STAT);
    end
  end

  assert_no_access_R3: assert property (@(posedge clk) disable iff (rst)
    chipEnN |-> (strobes == '0));

  assert_unused_sel_R10: assert property (@(posedge clk) disable iff (rst)
    (effSel > SEL_DIV) |-> (strobes == '0));

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (addrStrobeN && $past(addrStrobeN)) |-> $stable(effSel));
endmodule

// File: rtl/sbm_host_datapath.sv
module sbm_host_datapath
  import sbm_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  effSel,
  input  hostStrobeT        strobes,
  input  logic              chipEnN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              irqN,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] divReg,
  output logic              txLoad,
  output logic [DATA_W-1:0] txData,
  output logic              rxClear,
  input  logic [DATA_W-1:0] rxData,
  input  logic              flagPresence,
  input  logic              flagTbe,
  input  logic              flagTemt,
  input  logic              flagRbf
);
  logic [DATA_W-1:0] ienReg, statusNow, maskedNow, maskPrev, freshSrc;
  logic              irqActive;

  always_comb begin
    statusNow           = '0;
    statusNow[BIT_PRES] = flagPresence;
    statusNow[BIT_TBE]  = flagTbe;
    statusNow[BIT_TEMT] = flagTemt;
    statusNow[BIT_RBF]  = flagRbf;
  end

  assign maskedNow = statusNow & ienReg;
  assign freshSrc  = maskedNow & ~maskPrev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cmdReg  <= '0;
      ienReg  <= '0;
      divReg  <= '0;
      txData  <= '0;
      txLoad  <= 1'b0;
      rxClear <= 1'b0;
    end else begin
      if (strobes.wrCmd) cmdReg <= dataIn;
      if (strobes.wrIen) ienReg <= dataIn & IEN_MASK;
      if (strobes.wrDiv) divReg <= dataIn & DIV_MASK;
      if (strobes.wrTx)  txData <= dataIn;
      txLoad  <= strobes.wrTx;
      rxClear <= strobes.rdRx;
    end
  end

  // interrupt: set by a newly enabled source, cleared by a status read
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      maskPrev  <= '0;
      irqActive <= 1'b0;
    end else begin
      maskPrev <= maskedNow;
      if (|freshSrc)          irqActive <= 1'b1;
      else if (strobes.rdIrq) irqActive <= 1'b0;
    end
  end

  assign irqN   = ~irqActive;
  assign dataOe = ~chipEnN & ~rdN & wrN;

  always_comb begin
    dataOut = '0;
    if (dataOe) begin
      case (effSel)
        SEL_CMD:  dataOut = cmdReg;
        SEL_XFER: dataOut = rxData;
        SEL_STAT: dataOut = statusNow;
        SEL_IEN:  dataOut = ienReg;
        SEL_DIV:  dataOut = divReg;
        default:  dataOut = '0;
      endcase
    end
  end

  assert_txload_single_R8: assert property (@(posedge clk) disable iff (rst)
    txLoad |=> !txLoad);

  assert_rxclear_single_R9: assert property (@(posedge clk) disable iff (rst)
    rxClear |=> !rxClear);

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.rdIrq && (freshSrc == '0)) |=> irqN);

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
    (freshSrc != '0) |=> !irqN);

  assert_div_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strobes.wrDiv |=> $stable(divReg));
endmodule

// File: rtl/sbm_host_regs.sv
module sbm_host_regs
  import sbm_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  selIn,
  input  logic              addrStrobeN,
  input  logic              chipEnN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              irqN,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] divReg,
  output logic              txLoad,
  output logic [DATA_W-1:0] txData,
  output logic              rxClear,
  input  logic [DATA_W-1:0] rxData,
  input  logic              flagPresence,
  input  logic              flagTbe,
  input  logic              flagTemt,
  input  logic              flagRbf
);
  logic [SEL_W-1:0] effSel;
  hostStrobeT       strobes;

  sbm_host_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .selIn(selIn), .addrStrobeN(addrStrobeN),
    .chipEnN(chipEnN), .rdN(rdN), .wrN(wrN),
    .effSel(effSel), .strobes(strobes)
  );

  sbm_host_datapath dp_i (
    .clk(clk), .rst(rst), .effSel(effSel), .strobes(strobes),
    .chipEnN(chipEnN), .rdN(rdN), .wrN(wrN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .irqN(irqN),
    .cmdReg(cmdReg), .divReg(divReg), .txLoad(txLoad), .txData(txData),
    .rxClear(rxClear), .rxData(rxData),
    .flagPresence(flagPresence), .flagTbe(flagTbe),
    .flagTemt(flagTemt), .flagRbf(flagRbf)
  );
endmodule

// File: tb/sbm_host_regs_tb_top.sv
module sbm_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] selIn = '0;
  logic       addrStrobeN = 1'b0, chipEnN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] dataIn = '0, rxData = '0;
  logic       flagPresence = 0, flagTbe = 0, flagTemt = 0, flagRbf = 0;
  logic [7:0] dataOut, cmdReg, divReg, txData;
  logic       dataOe, irqN, txLoad, rxClear;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit modelLive = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbm_host_regs dut_i (
    .clk(clk), .rst(rst), .selIn(selIn), .addrStrobeN(addrStrobeN),
    .chipEnN(chipEnN), .rdN(rdN), .wrN(wrN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .irqN(irqN), .cmdReg(cmdReg),
    .divReg(divReg), .txLoad(txLoad), .txData(txData), .rxClear(rxClear),
    .rxData(rxData), .flagPresence(flagPresence), .flagTbe(flagTbe),
    .flagTemt(flagTemt), .flagRbf(flagRbf)
  );

  // reference model state
  logic [7:0] mCmd, mIen, mDiv, mTx, mMaskPrev;
  logic [2:0] mSelHeld;
  bit mIrq, mTxLoad, mRxClr;
  bit w1, w2, w3, r1, r2, r3;

  function automatic logic [7:0] statusOf();
    return {3'b000, flagRbf, flagTemt, flagTbe, 1'b0, flagPresence};
  endfunction

  function automatic logic [2:0] curSel();
    return addrStrobeN ? mSelHeld : selIn;
  endfunction

  always @(posedge clk or posedge rst) begin : model
    logic [2:0] sel;
    logic [7:0] masked, fresh;
    bit wrEv, rdEv;
    if (rst) begin
      mCmd = 0; mIen = 0; mDiv = 0; mTx = 0; mMaskPrev = 0; mSelHeld = 0;
      mIrq = 0; mTxLoad = 0; mRxClr = 0;
      w1 = 1; w2 = 1; w3 = 1; r1 = 1; r2 = 1; r3 = 1;
    end else begin
      sel    = curSel();
      wrEv   = w3 && !w2 && !chipEnN;
      rdEv   = r3 && !r2 && w2 && !chipEnN;
      masked = statusOf() & mIen;
      fresh  = masked & ~mMaskPrev;
      mTxLoad = wrEv && sel == 3'd1;
      mRxClr  = rdEv && sel == 3'd1;
      if (fresh != 0) mIrq = 1;
      else if (rdEv && sel == 3'd2) mIrq = 0;
      mMaskPrev = masked;
      if (wrEv) begin
        case (sel)
          3'd0: mCmd = dataIn;
          3'd1: mTx  = dataIn;
          3'd3: mIen = dataIn & 8'h1D;
          3'd4: mDiv = dataIn & 8'h1F;
          default: ;
        endcase
      end
      w3 = w2; w2 = w1; w1 = wrN;
      r3 = r2; r2 = r1; r1 = rdN;
      if (!addrStrobeN) mSelHeld = selIn;
    end
    modelLive = 1;
  end

  function automatic logic [7:0] expData();
    if (chipEnN || rdN || !wrN) return 8'h00;
    case (curSel())
      3'd0: return mCmd;
      3'd1: return rxData;
      3'd2: return statusOf();
      3'd3: return mIen;
      3'd4: return mDiv;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (modelLive) begin
      cmp("R1 cmdReg", cmdReg, mCmd);
      cmp("R11 divReg", divReg, mDiv);
      cmp("R10 dataOut", dataOut, expData());
      cmp("R3 dataOe", {7'b0, dataOe}, {7'b0, !chipEnN && !rdN && wrN});
      cmp("R5 irqN", {7'b0, irqN}, {7'b0, !mIrq});
      cmp("R8 txLoad", {7'b0, txLoad}, {7'b0, mTxLoad});
      cmp("R8 txData", txData, mTx);
      cmp("R9 rxClear", {7'b0, rxClear}, {7'b0, mRxClr});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hostWrite(logic [2:0] sel, logic [7:0] d, logic ce = 1'b0);
    selIn = sel; dataIn = d; chipEnN = ce; tick(1);
    wrN = 0; tick(4);
    wrN = 1; tick(3);
    chipEnN = 1; tick(1);
  endtask

  task automatic hostRead(logic [2:0] sel, logic ce = 1'b0);
    selIn = sel; chipEnN = ce; tick(1);
    rdN = 0; tick(4);
    rdN = 1; tick(3);
    chipEnN = 1; tick(1);
  endtask

  initial begin
    tick(3);
    rst = 0; tick(2);                       // R7 reset values checked by monitor
    // R1 / R12: command, enable, divisor writes and readback
    hostWrite(3'd0, 8'hA5); hostRead(3'd0);
    hostWrite(3'd3, 8'hFF); hostRead(3'd3);  // R11 enable mask
    hostWrite(3'd4, 8'hFF); hostRead(3'd4);  // R11 divisor mask
    hostWrite(3'd4, 8'h10);
    // R8 transmit load pulse
    hostWrite(3'd1, 8'h3C);
    // R9 receive read and clear pulse
    rxData = 8'h5A; hostRead(3'd1);
    // R5 / R6: interrupt set and clear
    flagTbe = 1; tick(3);
    hostRead(3'd2);                          // R11 status layout, R6 clear
    flagRbf = 1; tick(2); flagTemt = 1; flagPresence = 1; tick(2);
    hostRead(3'd2);
    // R5: enable an already-flagged source
    hostWrite(3'd3, 8'h00); hostRead(3'd2);
    hostWrite(3'd3, 8'h08); tick(2);
    hostRead(3'd2);
    // R10 unused selects
    hostWrite(3'd5, 8'h77); hostWrite(3'd7, 8'h12);
    hostRead(3'd5); hostRead(3'd6); hostRead(3'd7);
    // R3 chip enable high blocks access
    hostWrite(3'd0, 8'h11, 1'b1); hostRead(3'd1, 1'b1);
    // R4 simultaneous strobes: write wins
    selIn = 3'd1; dataIn = 8'h42; chipEnN = 0; tick(1);
    rdN = 0; wrN = 0; tick(4); rdN = 1; wrN = 1; tick(3);
    selIn = 3'd2; tick(1); rdN = 0; wrN = 0; tick(4); rdN = 1; wrN = 1; tick(3);
    chipEnN = 1; tick(1);
    // R2 address latch holds after strobe rises
    selIn = 3'd0; addrStrobeN = 0; tick(1);
    addrStrobeN = 1; tick(1);
    selIn = 3'd4; dataIn = 8'h66; chipEnN = 0; tick(1);
    wrN = 0; tick(4); wrN = 1; tick(3); rdN = 0; tick(3); rdN = 1; tick(3);
    chipEnN = 1; addrStrobeN = 0; tick(2);
    // R7 reset in mid-run
    hostWrite(3'd0, 8'h99);
    rst = 1; tick(2); rst = 0; tick(3);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule